// File: doc/BRIEF.md
# Incrementing-Complement RAM Self-Test

This block is a built-in self-test engine for one single-port synchronous RAM with a one-cycle read latency. The RAM sits outside the block. The engine owns the RAM's address, write-data, write-enable and read-enable lines for the length of a test and watches the returned read data. A single-cycle start pulse, given while the engine is idle, launches a test. When the test ends, the engine reports a one-cycle done strobe and a pass/fail result. It also keeps a fail flag that only reset clears, and it drives that flag out as an interrupt that cannot be masked.

A test has four sweeps over the whole address space, always in ascending address order:
- The first sweep fills every word with a value derived from its address.
- The second sweep reads each word and checks it against that value.
- The third sweep reads each word and writes back the bitwise inverse of the data it has just read.
- The fourth sweep reads each word and checks it against the inverse of the address-derived value.

Together these sweeps show that every cell can hold both a 0 and a 1. The engine records the address of the first mismatch seen in a run and always finishes the full sequence before it reports.

Top module: `ramtest_engine`

## Requirements
- R1: While `rst_n` is low at a clock edge, the engine returns to idle. `mem_we_o`, `mem_re_o`, `done_o`, `pass_o`, `fail_sticky_o` and `irq_o` are low and `fail_addr_o` is zero.
- R2: `start_i` high at an edge while idle begins a test. From the next cycle, for N = 2^AW cycles, address A = 0..N-1 is written, one per cycle, with the pattern P(A). Bit i of P(A) equals bit (i mod AW) of A.
- R3: Straight after the fill, address 0..N-1 is read, one per cycle. The data returned in the following cycle is compared against P(A).
- R4: Next, each address in ascending order gets one read cycle followed by one write cycle to the same address. The write data is the bitwise inverse of the read data returned in that write cycle.
- R5: Next, address 0..N-1 is read, one per cycle. The data returned in the following cycle is compared against the inverse of P(A).
- R6: After the last read, one cycle passes with no RAM access, and then `done_o` is high for exactly one cycle. This is 5N+2 cycles after the start edge.
- R7: `pass_o` goes high in the done cycle only if no compare of that run mismatched. It holds its value until the next accepted start, which clears it.
- R8: Any mismatch sets `fail_sticky_o`, and `irq_o` follows it with no mask. Both stay set through later runs, including passing ones, until reset.
- R9: `fail_addr_o` is cleared when a start is accepted. It then holds the address of the first mismatch in time of the run, whatever the mismatches that follow.
- R10: `start_i` has no effect while a test is running.
- R11: `mem_we_o` and `mem_re_o` are never high together, and both are low while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Launch pulse, accepted only while idle |
| mem_addr_o | output | AW | RAM address |
| mem_wdata_o | output | DW | RAM write data |
| mem_we_o | output | 1 | RAM write enable |
| mem_re_o | output | 1 | RAM read enable |
| mem_rdata_i | input | DW | RAM read data, valid one cycle after the read |
| done_o | output | 1 | One-cycle end-of-test strobe |
| pass_o | output | 1 | Result of the last finished test |
| fail_sticky_o | output | 1 | Fail flag, cleared only by reset |
| irq_o | output | 1 | Interrupt that cannot be masked, raised on any failure |
| fail_addr_o | output | AW | Address of the first mismatch of the run |

## Verification
The engine is run against a behavioural RAM with injectable stuck-at bits, and each pattern separates a different class of behaviour:
- A fault-free RAM shows the exact per-cycle bus trace and a clean pass.
- A bit stuck at the opposite of its fill value is caught in the first compare sweep.
- A bit stuck at the same value as its fill value escapes that sweep and is caught only after the inverse write-back. This separates a genuine read-modify-write from a plain second background.
- Two faults, with the higher address detected first in time, show that first-in-time capture is used rather than lowest-address capture.
- A clean rerun after a failure separates the per-run result from the sticky flag.
- A start pulse in mid-run shows that starts are ignored while busy.

// File: rtl/ramtest_pkg.sv
// Shared types of the RAM self-test engine.
// Assumes: nothing beyond a synthesizable enum.
package ramtest_pkg;

    // Sequencer states, one per sweep plus idle, settle and report cycles
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_CHK_UP,
        ST_RMW_RD,
        ST_RMW_WR,
        ST_CHK_INV,
        ST_SETTLE,
        ST_REPORT
    } rt_state_e;

endpackage

// File: rtl/ramtest_patgen.sv
// Address-derived background generator.
// Output bit i is address bit (i mod AW): the address is truncated when
// DW <= AW and repeated cyclically when DW > AW.
// Assumes: AW >= 1, DW >= 1. Purely combinational.
module ramtest_patgen #(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input  logic [AW-1:0] addr_i,
    output logic [DW-1:0] pat_o
);

    // one wire per data bit, picking the matching address bit
    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign pat_o[i] = addr_i[i % AW];
    end

endmodule

// File: rtl/ramtest_seq.sv
// Sweep sequencer: walks the address space four times and issues RAM
// commands. The read-modify-write sweep takes two cycles per address.
// Assumes: the RAM returns read data one cycle after a read.
module ramtest_seq
    import ramtest_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic [AW-1:0] addr_o,
    output logic          launch_o,
    output logic          busy_o,
    output logic          we_o,
    output logic          re_o,
    output logic          wb_sel_o,
    output logic          chk_o,
    output logic          inv_o,
    output logic          settle_o,
    output logic          done_o
);

    localparam logic [AW-1:0] LAST_ADDR = '1;

    rt_state_e     state_q;
    logic [AW-1:0] addr_q;
    logic          at_last;

    assign at_last  = (addr_q == LAST_ADDR);
    assign launch_o = (state_q == ST_IDLE) && start_i;

    // state and address advance; start only honoured from idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    addr_q <= '0;
                    if (start_i) state_q <= ST_FILL;
                end
                ST_FILL: begin
                    addr_q <= addr_q + 1'b1;
                    if (at_last) state_q <= ST_CHK_UP;
                end
                ST_CHK_UP: begin
                    addr_q <= addr_q + 1'b1;
                    if (at_last) state_q <= ST_RMW_RD;
                end
                ST_RMW_RD: begin
                    state_q <= ST_RMW_WR;
                end
                ST_RMW_WR: begin
                    addr_q  <= addr_q + 1'b1;
                    state_q <= at_last ? ST_CHK_INV : ST_RMW_RD;
                end
                ST_CHK_INV: begin
                    addr_q <= addr_q + 1'b1;
                    if (at_last) state_q <= ST_SETTLE;
                end
                ST_SETTLE: state_q <= ST_REPORT;
                ST_REPORT: state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    // command decode from the current state
    always_comb begin
        we_o     = (state_q == ST_FILL) || (state_q == ST_RMW_WR);
        re_o     = (state_q == ST_CHK_UP) || (state_q == ST_RMW_RD) ||
                   (state_q == ST_CHK_INV);
        wb_sel_o = (state_q == ST_RMW_WR);
        chk_o    = (state_q == ST_CHK_UP) || (state_q == ST_CHK_INV);
        inv_o    = (state_q == ST_CHK_INV);
        settle_o = (state_q == ST_SETTLE);
        done_o   = (state_q == ST_REPORT);
        busy_o   = (state_q != ST_IDLE);
    end

    assign addr_o = addr_q;

endmodule

// File: rtl/ramtest_cmp.sv
// Compare stage: delays the expected value and address by one cycle to
// line up with the RAM read data. It flags mismatches, captures the first
// failing address of a run, and keeps the per-run and sticky results.
// Assumes: read data is valid exactly one cycle after chk_i.
module ramtest_cmp #(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch_i,
    input  logic          chk_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] exp_i,
    input  logic [DW-1:0] rdata_i,
    input  logic          settle_i,
    output logic          pass_o,
    output logic          sticky_o,
    output logic [AW-1:0] fail_addr_o
);

    logic          pend_q;
    logic [AW-1:0] pend_addr_q;
    logic [DW-1:0] pend_exp_q;
    logic          run_fail_q;
    logic          miss;

    assign miss = pend_q && (rdata_i != pend_exp_q);

    // one-cycle delay of the compare request to match read latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_addr_q <= '0;
            pend_exp_q  <= '0;
        end else begin
            pend_q      <= chk_i;
            pend_addr_q <= addr_i;
            pend_exp_q  <= exp_i;
        end
    end

    // per-run fail bit and first failing address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_fail_q  <= 1'b0;
            fail_addr_o <= '0;
        end else if (launch_i) begin
            run_fail_q  <= 1'b0;
            fail_addr_o <= '0;
        end else if (miss) begin
            run_fail_q <= 1'b1;
            if (!run_fail_q) fail_addr_o <= pend_addr_q;
        end
    end

    // result latched on the settle cycle, sticky flag cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass_o   <= 1'b0;
            sticky_o <= 1'b0;
        end else begin
            if (launch_i)      pass_o <= 1'b0;
            else if (settle_i) pass_o <= !(run_fail_q || miss);
            if (miss) sticky_o <= 1'b1;
        end
    end

endmodule

// File: rtl/ramtest_engine.sv
// Top of the incrementing/complement RAM self-test engine.
// Ties the sequencer, background generator and compare stage together and
// owns the external RAM port.
// Assumes: single-port synchronous RAM with 2^AW words and a read latency
// of one cycle. The RAM is not accessed by anyone else during a test.
module ramtest_engine
    import ramtest_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    output logic          mem_we_o,
    output logic          mem_re_o,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          done_o,
    output logic          pass_o,
    output logic          fail_sticky_o,
    output logic          irq_o,
    output logic [AW-1:0] fail_addr_o
);

    logic          launch, busy, wb_sel, chk, inv, settle;
    logic [AW-1:0] addr;
    logic [DW-1:0] pat, expect_val;

    ramtest_seq #(.AW(AW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .addr_o   (addr),
        .launch_o (launch),
        .busy_o   (busy),
        .we_o     (mem_we_o),
        .re_o     (mem_re_o),
        .wb_sel_o (wb_sel),
        .chk_o    (chk),
        .inv_o    (inv),
        .settle_o (settle),
        .done_o   (done_o)
    );

    ramtest_patgen #(.AW(AW), .DW(DW)) u_pat (
        .addr_i (addr),
        .pat_o  (pat)
    );

    // expected value for the current compare sweep
    assign expect_val = inv ? ~pat : pat;

    // write data: the background on fill, the inverse of the read data on write-back
    always_comb begin
        if (wb_sel)        mem_wdata_o = ~mem_rdata_i;
        else if (mem_we_o) mem_wdata_o = pat;
        else               mem_wdata_o = '0;
    end

    assign mem_addr_o = addr;

    ramtest_cmp #(.AW(AW), .DW(DW)) u_cmp (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch_i    (launch),
        .chk_i       (chk),
        .addr_i      (addr),
        .exp_i       (expect_val),
        .rdata_i     (mem_rdata_i),
        .settle_i    (settle),
        .pass_o      (pass_o),
        .sticky_o    (fail_sticky_o),
        .fail_addr_o (fail_addr_o)
    );

    // failure interrupt has no mask
    assign irq_o = fail_sticky_o;

endmodule

// File: rtl/ramtest_chk.sv
// Assertion checker for ramtest_engine, attached by bind below.
// Assumes: it observes ports plus the internal busy flag.
module ramtest_chk #(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic [AW-1:0] mem_addr_o,
    input logic [DW-1:0] mem_wdata_o,
    input logic          mem_we_o,
    input logic          mem_re_o,
    input logic [DW-1:0] mem_rdata_i,
    input logic          done_o,
    input logic          pass_o,
    input logic          fail_sticky_o
);

    p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we_o && mem_re_o));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we_o && !mem_re_o));

    p_fill_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && $past(mem_we_o)) |-> mem_addr_o == AW'($past(mem_addr_o) + 1'b1));

    p_writeback_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && $past(mem_re_o)) |->
            (mem_addr_o == $past(mem_addr_o) && mem_wdata_o == ~mem_rdata_i));

    p_done_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_pass_at_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pass_o) |-> done_o);

    p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fail_sticky_o |=> fail_sticky_o);

endmodule

bind ramtest_engine ramtest_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .mem_addr_o    (mem_addr_o),
    .mem_wdata_o   (mem_wdata_o),
    .mem_we_o      (mem_we_o),
    .mem_re_o      (mem_re_o),
    .mem_rdata_i   (mem_rdata_i),
    .done_o        (done_o),
    .pass_o        (pass_o),
    .fail_sticky_o (fail_sticky_o)
);

// File: tb/test_ramtest_engine.sv
// Bench: behavioural RAM with stuck-at injection and a queue-based model of
// the expected bus trace, compared every clock.
module test_ramtest_engine;

    localparam int AW = 4;
    localparam int DW = 6;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic          we, re;
    logic [DW-1:0] rdata = '0;
    logic          done, pass, sticky, irq;
    logic [AW-1:0] faddr;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ramtest_engine #(.AW(AW), .DW(DW)) i_ramtest_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_we_o(we), .mem_re_o(re),
        .mem_rdata_i(rdata), .done_o(done), .pass_o(pass),
        .fail_sticky_o(sticky), .irq_o(irq), .fail_addr_o(faddr)
    );

    // fault injection: up to two stuck bits applied on writes
    bit f_en [2];
    int f_addr [2];
    int f_bit [2];
    bit f_val [2];

    function automatic logic [DW-1:0] inject(int a, logic [DW-1:0] d);
        logic [DW-1:0] r = d;
        for (int k = 0; k < 2; k++)
            if (f_en[k] && f_addr[k] == a) r[f_bit[k]] = f_val[k];
        return r;
    endfunction

    function automatic logic [DW-1:0] bpat(int a);
        logic [DW-1:0] r = '0;
        for (int i = 0; i < DW; i++) r[i] = a[i % AW];
        return r;
    endfunction

    logic [DW-1:0] ram [N];
    always @(posedge clk) begin
        if (we) ram[addr] <= inject(int'(addr), wdata);
        if (re) rdata <= ram[addr];
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    bit exp_sticky = 0;

    bit            q_re [$];
    bit            q_we [$];
    int            q_addr [$];
    logic [DW-1:0] q_wd [$];
    string         q_tag [$];

    task automatic push(bit r, bit w, int a, logic [DW-1:0] d, string t);
        q_re.push_back(r); q_we.push_back(w); q_addr.push_back(a);
        q_wd.push_back(d); q_tag.push_back(t);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!we && !re && !done && !pass && !sticky && !irq && faddr == 0, "R1 reset state",
              32'({we, re, done, pass, sticky, irq, faddr}), 32'(0));
        rst_n = 1'b1;
        exp_sticky = 0;
    endtask

    task automatic run_test(input string name, input bit poke_start);
        logic [DW-1:0] sh [N];
        bit xfail = 0;
        int xaddr = 0;
        q_re.delete(); q_we.delete(); q_addr.delete(); q_wd.delete(); q_tag.delete();
        for (int a = 0; a < N; a++) sh[a] = ram[a];
        for (int a = 0; a < N; a++) begin
            push(1'b0, 1'b1, a, bpat(a), "R2 fill");
            sh[a] = inject(a, bpat(a));
        end
        for (int a = 0; a < N; a++) begin
            push(1'b1, 1'b0, a, '0, "R3 read-up");
            if (sh[a] != bpat(a) && !xfail) begin xfail = 1; xaddr = a; end
        end
        for (int a = 0; a < N; a++) begin
            push(1'b1, 1'b0, a, '0, "R4 rmw read");
            push(1'b0, 1'b1, a, ~sh[a], "R4 rmw write");
            sh[a] = inject(a, ~sh[a]);
        end
        for (int a = 0; a < N; a++) begin
            push(1'b1, 1'b0, a, '0, "R5 read-inv");
            if (sh[a] != ~bpat(a) && !xfail) begin xfail = 1; xaddr = a; end
        end
        if (xfail) exp_sticky = 1;

        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int c = 0; c < q_re.size(); c++) begin
            if (c > 0) @(negedge clk);
            if (poke_start && c == 20) start = 1'b1;   // R10 start mid-run
            if (poke_start && c == 21) start = 1'b0;
            check(re == q_re[c] && we == q_we[c] && int'(addr) == q_addr[c] &&
                  (!q_we[c] || wdata == q_wd[c]) && !(re && we),
                  {name, " ", q_tag[c], " R11"},
                  32'({re, we, addr, wdata}), 32'({q_re[c], q_we[c], AW'(q_addr[c]), q_wd[c]}));
            check(!done, {name, " R6 no early done"}, 32'(done), 32'(0));
        end
        @(negedge clk);
        check(!re && !we && !done, {name, " R6 settle cycle"}, 32'({re, we, done}), 32'(0));
        @(negedge clk);
        check(done, {name, " R6 done strobe"}, 32'(done), 32'(1));
        check(pass == !xfail, {name, " R7 pass"}, 32'(pass), 32'(!xfail));
        check(int'(faddr) == xaddr, {name, " R9 first fail addr"}, 32'(faddr), 32'(xaddr));
        check(sticky == exp_sticky && irq == exp_sticky, {name, " R8 sticky/irq"},
              32'({sticky, irq}), 32'({exp_sticky, exp_sticky}));
        @(negedge clk);
        check(!done, {name, " R6 done once"}, 32'(done), 32'(0));
        check(pass == !xfail, {name, " R7 pass held"}, 32'(pass), 32'(!xfail));
        check(!re && !we, {name, " R11 idle quiet"}, 32'({re, we}), 32'(0));
    endtask

    initial begin
        for (int a = 0; a < N; a++) ram[a] = '0;
        for (int k = 0; k < 2; k++) begin f_en[k] = 0; f_addr[k] = 0; f_bit[k] = 0; f_val[k] = 0; end
        do_reset();
        run_test("clean", 1'b0);
        run_test("R10 midstart", 1'b1);
        // stuck-at-0 on a bit the fill sets: caught by the first compare
        f_en[0] = 1; f_addr[0] = 5; f_bit[0] = 0; f_val[0] = 0;
        run_test("stuck0", 1'b0);
        f_en[0] = 0;
        run_test("R8 rerun clean", 1'b0);
        do_reset();
        // stuck-at-1 matching the fill: caught only after the inverse write-back
        f_en[1] = 1; f_addr[1] = 3; f_bit[1] = 0; f_val[1] = 1;
        run_test("R5 stuck1", 1'b0);
        // two faults: address 9 caught first in time, address 2 only later
        f_en[0] = 1; f_addr[0] = 9; f_bit[0] = 0; f_val[0] = 0;
        f_addr[1] = 2; f_bit[1] = 1; f_val[1] = 1;
        run_test("R9 two faults", 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R6 test did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule